// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that moves 8-bit bytes out on `mosi` and, in the same clock cycles, collects 8 bits from `miso`. Two single-byte holding registers sit in front of the shift engine. One is a transmit slot that the bus side fills through a valid/ready write stream. The other is a receive slot that the bus side drains through a valid/ready read stream. The serial clock is made from the system clock by a fixed divider parameter. Three plain configuration pins choose the idle clock level, the clock phase and the bit order. These pins must be held steady while a transfer is in progress.

Back-pressure rules. On the write side, `tx_ready` is the transmit-empty flag. A beat is taken only in a cycle where both `tx_valid` and `tx_ready` are high. If `tx_valid` is high while `tx_ready` is low, the beat is dropped, not stalled, so a producer must wait for `tx_ready` before it offers a byte. On the read side, `rx_valid` is the receive-full flag and stays high until a cycle with `rx_ready` high takes the byte. The serial side is never stalled. If a byte completes while the receive slot is still full, the new byte is discarded without any indication.

When a transfer ends and the transmit slot already holds a byte, the next transfer starts straight away and `ss_n` stays low. A caller can therefore keep the link busy by writing each new byte whenever `tx_ready` rises.

Top module: `spi_dbuf_master`

## Requirements
- R1: While `rst` is high and after it is released, `tx_ready` is 1, `rx_valid` is 0, `ss_n` is 1, `mosi` is 0 and `sck` equals `cfg_cpol`.
- R2: A write beat is accepted only when `tx_ready` is 1, and `tx_ready` falls in the next cycle. A beat offered while `tx_ready` is 0 is ignored: that byte is never transmitted.
- R3: When the shift engine is free and the transmit slot is full, the byte moves into the engine in the next cycle and `tx_ready` rises again at that same clock edge.
- R4: With H = `HALF_DIV`, `ss_n` falls at the load edge. The first `sck` transition comes H clocks later, followed by 16 transitions spaced H clocks apart. The transfer completes H clocks after the 16th transition.
- R5: The idle level of `sck` is `cfg_cpol` (0 = idle low, 1 = idle high). `sck` returns to that level after the 16th transition.
- R6: With `cfg_cpha`=0, the first bit is on `mosi` from the load edge, `miso` is sampled on transitions 1, 3, …, 15, and `mosi` advances on transitions 2, 4, …, 14. With `cfg_cpha`=1, `mosi` advances on transitions 1, 3, …, 15 and `miso` is sampled on transitions 2, 4, …, 16.
- R7: With `cfg_lsb_first`=0, bit 7 is sent and received first. With `cfg_lsb_first`=1, bit 0 is first. The setting applies to both directions.
- R8: On completion, if the receive slot is empty, the collected byte appears on `rx_data` and `rx_valid` rises. A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid`.
- R9: If the transmit slot is full at completion, the next transfer loads at that same edge, `ss_n` stays low, and its first `sck` transition comes H clocks later.
- R10: If `rx_valid` is high at completion, even in a cycle where `rx_ready` is high, the new byte is dropped and `rx_data` keeps the older byte. No status changes.
- R11: At completion with no byte queued, `ss_n` rises and `mosi` returns to 0. Both stay there while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on odd transitions; 1: sample on even transitions |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| tx_valid | input | 1 | Write beat offered |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmit slot empty; a beat is taken when both are high |
| rx_valid | output | 1 | Receive slot full |
| rx_data | output | 8 | Oldest received byte not yet read |
| rx_ready | input | 1 | Takes the received byte when `rx_valid` is high |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, active low |

## Verification
On every cycle, the assertions check the following. Serial clock transitions happen only with `ss_n` low. Half-period ticks are never adjacent. The edge count never goes past 16. `sck` and `mosi` sit at their idle values whenever the engine is idle. A full slot ignores pushes and keeps its byte. A load reopens the transmit slot, completion fills an empty receive slot, and a completion with a byte queued keeps `ss_n` low. Only the bench's scenarios can show the following: the exact edge timing, the bit order and the sample/launch phase of each of the four clock formats (checked by a behavioural slave that captures `mosi` and drives `miso`), dropping of a write offered while busy, chaining with no gap, and keeping the older byte on overrun. All of these are compared against a clock-by-clock reference model.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  // Serial format selection, held stable during a transfer
  typedef struct packed {
    logic cpol;       // idle level of the serial clock
    logic cpha;       // 0: sample on odd edges, 1: sample on even edges
    logic lsb_first;  // 1: bit 0 travels first
  } spi_fmt_t;
endpackage

// File: rtl/spi_half_tick.sv
// Half-period strobe for the serial clock; HALF_DIV must be at least 2.
module spi_half_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
endmodule

// File: rtl/spi_hold_reg.sv
// One-entry holding slot: a push is taken only while empty.
module spi_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] dout
);
  logic take_in;
  assign take_in = push && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      dout <= '0;
    end else begin
      if (take_in)   full <= 1'b1;
      else if (pop)  full <= 1'b0;
      if (take_in)   dout <= din;
    end
  end

  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> full && $stable(dout)); // R2, R10
endmodule

// File: rtl/spi_shift_engine.sv
// Serialiser/deserialiser with the four clock formats.
module spi_shift_engine
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_fmt_t          fmt,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              take,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              ss_n_o,
  input  logic              miso
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES);

  logic [EW-1:0]     edge_cnt;
  logic [EW-1:0]     next_edge;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              sck_q, mosi_q, ss_q;
  logic              sample_now;
  logic              free;

  function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign next_edge  = edge_cnt + 1'b1;
  // odd edges sample when phase is 0, even edges sample when phase is 1
  assign sample_now = next_edge[0] ^ fmt.cpha;
  assign done       = busy && tick && (edge_cnt == LAST_EDGE);
  assign free       = !busy || done;
  assign take       = free && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      ss_q     <= 1'b1;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (take) begin
      busy     <= 1'b1;
      ss_q     <= 1'b0;
      edge_cnt <= '0;
      if (!fmt.cpha) begin
        mosi_q <= head_bit(tx_byte, fmt.lsb_first);
        tx_sh  <= advance(tx_byte, fmt.lsb_first);
      end else begin
        tx_sh  <= tx_byte;
      end
    end else if (done) begin
      busy   <= 1'b0;
      ss_q   <= 1'b1;
      mosi_q <= 1'b0;
    end else if (busy && tick && (edge_cnt != LAST_EDGE)) begin
      edge_cnt <= next_edge;
      sck_q    <= ~sck_q;
      if (sample_now) begin
        rx_sh <= fmt.lsb_first ? {miso, rx_sh[DATA_W-1:1]}
                               : {rx_sh[DATA_W-2:0], miso};
      end else if (fmt.cpha || (next_edge != LAST_EDGE)) begin
        mosi_q <= head_bit(tx_sh, fmt.lsb_first);
        tx_sh  <= advance(tx_sh, fmt.lsb_first);
      end
    end
  end

  assign rx_byte = rx_sh;
  assign sck_o   = sck_q ^ fmt.cpol;
  assign mosi_o  = mosi_q;
  assign ss_n_o  = ss_q;

  AST_SCK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck_q) |-> !ss_q); // R4
  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    edge_cnt <= LAST_EDGE); // R4
  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck_o == fmt.cpol)); // R5
  AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mosi_o && ss_n_o); // R11
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  spi_fmt_t          fmt;
  logic              tx_full;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] shift_rx;
  logic              take, done, busy, tick;

  assign fmt = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

  spi_hold_reg #(.W(DATA_W)) i_tx_slot (
    .clk(clk), .rst(rst),
    .push(tx_valid), .din(tx_data), .pop(take),
    .full(tx_full), .dout(tx_q)
  );

  spi_hold_reg #(.W(DATA_W)) i_rx_slot (
    .clk(clk), .rst(rst),
    .push(done), .din(shift_rx), .pop(rx_ready),
    .full(rx_valid), .dout(rx_data)
  );

  spi_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) i_engine (
    .clk(clk), .rst(rst), .fmt(fmt), .tick(tick),
    .avail(tx_full), .tx_byte(tx_q),
    .take(take), .done(done), .busy(busy), .rx_byte(shift_rx),
    .sck_o(sck), .mosi_o(mosi), .ss_n_o(ss_n), .miso(miso)
  );

  assign tx_ready = !tx_full;

  AST_LOAD_FREES_SLOT: assert property (@(posedge clk) disable iff (rst)
    take |=> tx_ready); // R3
  AST_DONE_FILLS_RX: assert property (@(posedge clk) disable iff (rst)
    done && !rx_valid |=> rx_valid); // R8
  AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    done && rx_valid |=> $stable(rx_data)); // R10
  AST_CHAIN_HOLDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    done && take |=> !ss_n); // R9
endmodule

// File: tb/test_spi_dbuf_master.sv
module test_spi_dbuf_master;
  localparam int H = 4;
  localparam int EDGES = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpol = 1'b0, cpha = 1'b0, lsbf = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic sck, mosi, ss_n;
  logic miso = 1'b0;

  int checks = 0, fails = 0, cycles = 0;

  // reference model state
  bit m_txfull, m_rxfull, m_busy;
  logic [7:0] m_txdata, m_rxdata;
  int m_t, m_idx;
  logic [7:0] m_sentq[$];

  always #10 clk = ~clk;

  spi_dbuf_master #(.DATA_W(8), .HALF_DIV(H)) i_spi_dbuf_master (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsbf),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  function automatic logic [7:0] slave_byte(input int i);
    return 8'(i * 29 + 60) ^ 8'hA5;
  endfunction

  function automatic logic bit_at(input logic [7:0] b, input int k, input logic lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model, advanced on each clock edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_txfull = 0; m_rxfull = 0; m_busy = 0; m_t = 0; m_idx = 0;
      m_sentq.delete();
    end else begin
      bit done, load, rx_acc, rx_pop, tx_acc;
      done   = m_busy && (m_t == (EDGES + 1) * H - 1);
      load   = (!m_busy || done) && m_txfull;
      rx_acc = done && !m_rxfull;
      rx_pop = rx_ready && m_rxfull;
      tx_acc = tx_valid && !m_txfull;
      if (rx_acc) m_rxdata = slave_byte(m_idx);
      if (done) m_idx++;
      if (rx_acc) m_rxfull = 1; else if (rx_pop) m_rxfull = 0;
      if (load) begin m_sentq.push_back(m_txdata); m_busy = 1; m_t = 0; end
      else if (done) begin m_busy = 0; m_t = 0; end
      else if (m_busy) m_t++;
      if (tx_acc) begin m_txfull = 1; m_txdata = tx_data; end
      else if (load) m_txfull = 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int eg;
      eg = m_busy ? ((m_t / H) > EDGES ? EDGES : (m_t / H)) : 0;
      chk(tx_ready == !m_txfull, "R2/R3 tx_ready", tx_ready, !m_txfull);
      chk(rx_valid == m_rxfull, "R8 rx_valid", rx_valid, m_rxfull);
      if (m_rxfull) chk(rx_data == m_rxdata, "R8/R10 rx_data", rx_data, m_rxdata);
      chk(sck == (cpol ^ eg[0]), "R4/R5 sck", sck, cpol ^ eg[0]);
      chk(ss_n == !m_busy, "R9/R11 ss_n", ss_n, !m_busy);
      if (!m_busy) chk(mosi == 1'b0, "R11 idle mosi", mosi, 0);
    end
  end

  // behavioural slave: drives miso, captures mosi
  logic prev_sck, prev_ss;
  int s_n, s_idx;
  logic [7:0] s_cap;
  always @(negedge clk) begin
    if (rst) begin
      prev_sck = sck; prev_ss = 1'b1; s_n = 0; s_idx = 0; s_cap = '0; miso = 1'b0;
    end else begin
      if (prev_ss && !ss_n) begin
        s_n = 0; s_cap = '0;
        if (!cpha) miso = bit_at(slave_byte(s_idx), 0, lsbf);
      end
      if (sck != prev_sck && !ss_n) begin
        int k;
        s_n++;
        k = (s_n - 1) / 2;
        if ((s_n % 2 == 1) ^ cpha) begin
          if (lsbf) s_cap[k] = mosi; else s_cap[7-k] = mosi;
        end else if (cpha) begin
          miso = bit_at(slave_byte(s_idx), k, lsbf);
        end else if (s_n < EDGES) begin
          miso = bit_at(slave_byte(s_idx), s_n / 2, lsbf);
        end
        if (s_n == EDGES) begin
          if (m_sentq.size() == 0) chk(0, "R2/R6/R7 unexpected byte", s_cap, 0);
          else begin
            logic [7:0] e;
            e = m_sentq.pop_front();
            chk(s_cap == e, "R6/R7 mosi byte", s_cap, e);
          end
          s_idx++; s_n = 0; s_cap = '0;
          if (!cpha) miso = bit_at(slave_byte(s_idx), 0, lsbf);
        end
      end
      prev_sck = sck; prev_ss = ss_n;
    end
  end

  task automatic put_raw(input logic [7:0] b);
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic put_ready(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic take_rx();
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy || m_txfull) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 60000) begin
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held in reset
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(sck == cpol, "R1 sck", sck, cpol);
    rst = 1'b0;

    // R5/R6/R7: every clock format and bit order, one byte each
    for (int m = 0; m < 8; m++) begin
      @(negedge clk);
      {cpol, cpha, lsbf} = 3'(m);
      repeat (2) @(negedge clk);
      put_ready(8'h3C ^ 8'(m * 17));
      take_rx();
      wait_idle();
    end

    // R9: chained transfers, reading while the next one runs
    {cpol, cpha, lsbf} = 3'b010;
    @(negedge clk);
    put_ready(8'hC3); put_ready(8'h81); put_ready(8'h7E);
    take_rx(); take_rx(); take_rx();
    wait_idle();

    // R2: write offered while the slot is full is dropped
    {cpol, cpha, lsbf} = 3'b111;
    @(negedge clk);
    put_ready(8'hA1); put_ready(8'hB2);
    put_raw(8'hEE);
    take_rx(); take_rx();
    wait_idle();

    // R10: overrun keeps the older byte, then a read in the completion cycle
    {cpol, cpha, lsbf} = 3'b001;
    @(negedge clk);
    put_ready(8'h11); put_ready(8'h22);
    wait_idle();
    chk(rx_valid == 1'b1, "R10 still full", rx_valid, 1);
    take_rx();
    put_ready(8'h33); put_ready(8'h44);
    take_rx();
    wait_idle();
    take_rx();
    wait_idle();
    chk(rx_valid == 1'b0, "R8 drained", rx_valid, 0);
    chk(ss_n == 1'b1, "R11 idle select", ss_n, 1);
    summary();
  end
endmodule